// File: doc/BRIEF.md
# Selectable-Encoding Serial Line Transmitter

This block puts a stream of already-framed synchronous bits onto one serial data line. Bits arrive one at a time through a valid/ready handshake, and a single bit register feeds an output encoder that runs in one of four line modes. Plain NRZ holds each bit level for a whole bit period. Manchester places a transition in the middle of every bit. Internally clocked NRZ also drives a bit clock whose rising edge falls in the middle of a stable bit. Externally clocked NRZ times its bits from a foreign bit clock that is first brought through a synchronizer.

Bit timing in the three self-timed modes comes from a rate enable that pulses at twice the bit rate, so each half-bit lasts one enable period. A sync-select input decides whether the line carries this encoder's output or an asynchronous UART-framed line that is passed straight through. Flag insertion, bit stuffing, CRC generation and the UART serializer belong to neighbouring blocks.

Top module: `sltx_top`

## Requirements
- R1: Once reset is released, and before any rate tick, `line_out` is high (with `sync_sel` set), `bclk_out` is low and `bit_ready` is low.
- R2: While `sync_sel` is 0, `line_out` equals `uart_line` in the same cycle, `bit_ready` stays low and `bclk_out` stays low.
- R3: With `tx_manch`=0 and `nrz_clk_sel`=0 (plain NRZ, value 3 also selects it), an accepted bit is driven as a high level for 1 and a low level for 0 for its whole bit period of two rate ticks, and `bclk_out` stays low.
- R4: With `tx_manch`=1, a 0 is sent high for the first half-bit and low for the second, and a 1 low then high, so the line changes at every mid-bit and the second half carries the bit value.
- R5: `tx_manch`=1 selects Manchester whatever the value of `nrz_clk_sel`. With both controls at 0, which is the reset setting used by the bench, the encoding is NRZ.
- R6: With `nrz_clk_sel`=1, `bclk_out` is low in the first half and high in the second half of each bit period, and it keeps running while the line is idle. `line_out` changes only when `bclk_out` falls, so it is stable at every rising edge.
- R7: With `nrz_clk_sel`=2, `rate_tick` has no effect. `ext_bclk` passes two synchronizing flops and one edge-detect flop. `bit_ready` pulses in the cycle after the second clock edge that samples `ext_bclk` low after it was high, and the new bit appears on `line_out` at the next edge, well before the next rising edge of `ext_bclk`.
- R8: If no bit is taken at a boundary, `line_out` is high for the whole following bit period in every synchronous mode.
- R9: In the self-timed modes, phase 0 follows reset. Each rate tick flips the phase, and a tick in phase 1 marks a bit boundary. `bit_ready` is high only in boundary cycles, never two cycles running, and a bit is taken only when `bit_valid` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_sel | input | 1 | 1 selects the synchronous encoder, 0 passes `uart_line` through |
| tx_manch | input | 1 | 1 forces Manchester encoding |
| nrz_clk_sel | input | 2 | NRZ timing: 0 plain, 1 internal clock, 2 external clock, 3 plain |
| rate_tick | input | 1 | Half-bit rate enable for the self-timed modes |
| ext_bclk | input | 1 | Foreign bit clock, asynchronous to `clk` |
| bit_valid | input | 1 | A bit is offered |
| bit_data | input | 1 | Offered bit value |
| bit_ready | output | 1 | Bit boundary: the offered bit is taken this cycle |
| uart_line | input | 1 | UART-framed line for asynchronous pass-through |
| line_out | output | 1 | Serial data line |
| bclk_out | output | 1 | Generated bit clock (internal-clock NRZ only) |

## Verification
The hardest situation to reach is the external-clock boundary. It can only come about when a real falling edge of `ext_bclk` has worked its way through the synchronizer while rate ticks keep arriving and must be ignored. The bench toggles `ext_bclk` with several half-periods that are unrelated to the tick spacing. Tick pulses run the whole time, so a design that lets a tick move a bit in that mode shows up at once. Directed segments add Manchester runs of all zeros and all ones, ticks on every cycle, and a fully idle internal-clock run in which the clock must keep toggling.

// File: rtl/sltx_pkg.sv
package sltx_pkg;

   typedef enum logic [1:0] {
      LM_PLAIN  = 2'd0,
      LM_INTCLK = 2'd1,
      LM_EXTCLK = 2'd2,
      LM_MANCH  = 2'd3
   } line_mode_e;

   // Manchester overrides the NRZ timing selection; code 3 falls back to plain
   function automatic line_mode_e resolve_mode(input logic manch, input logic [1:0] sel);
      line_mode_e m;
      if (manch)            m = LM_MANCH;
      else if (sel == 2'd1) m = LM_INTCLK;
      else if (sel == 2'd2) m = LM_EXTCLK;
      else                  m = LM_PLAIN;
      return m;
   endfunction

endpackage

// File: rtl/sltx_sync.sv
module sltx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic fall_seen
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("sltx_sync: STAGES must be at least 2");
   end

   logic [LAST:0] chain;
   logic          held;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
         held  <= 1'b0;
      end else begin
         chain[0] <= async_in;
         held     <= chain[LAST];
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign fall_seen = held & ~chain[LAST];

   assert_fall_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fall_seen |=> !fall_seen);

endmodule

// File: rtl/sltx_timer.sv
module sltx_timer (
   input  logic clk,
   input  logic rst_n,
   input  logic rate_tick,
   input  logic use_ext,
   input  logic ext_fall,
   output logic phase,
   output logic boundary
);
   always_ff @(posedge clk) begin
      if (!rst_n)                    phase <= 1'b0;
      else if (!use_ext && rate_tick) phase <= ~phase;
   end

   assign boundary = use_ext ? ext_fall : (rate_tick & phase);

   assert_ext_phase_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (use_ext && $past(use_ext)) |-> $stable(phase));

endmodule

// File: rtl/sltx_holder.sv
module sltx_holder (
   input  logic clk,
   input  logic rst_n,
   input  logic take,
   input  logic in_valid,
   input  logic in_bit,
   output logic cur_vld,
   output logic cur_bit
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_vld <= 1'b0;
         cur_bit <= 1'b1;
      end else if (take) begin
         cur_vld <= in_valid;
         if (in_valid) cur_bit <= in_bit;
      end
   end

   assert_hold_between_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !take |=> ($stable(cur_vld) && $stable(cur_bit)));

endmodule

// File: rtl/sltx_encoder.sv
module sltx_encoder
   import sltx_pkg::*;
#(
   parameter bit HAS_CLK_OUT = 1'b1
) (
   input  line_mode_e mode,
   input  logic       phase,
   input  logic       cur_vld,
   input  logic       cur_bit,
   input  logic       sync_sel,
   input  logic       uart_line,
   output logic       line_out,
   output logic       bclk_out
);
   logic sync_lvl;

   always_comb begin
      if (!cur_vld)              sync_lvl = 1'b1;
      else if (mode == LM_MANCH) sync_lvl = phase ? cur_bit : ~cur_bit;
      else                       sync_lvl = cur_bit;
      line_out = sync_sel ? sync_lvl : uart_line;
   end

   if (HAS_CLK_OUT) begin : g_clk_out
      assign bclk_out = sync_sel & (mode == LM_INTCLK) & phase;
   end else begin : g_no_clk_out
      assign bclk_out = 1'b0;
   end

endmodule

// File: rtl/sltx_top.sv
module sltx_top
   import sltx_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit HAS_CLK_OUT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sync_sel,
   input  logic       tx_manch,
   input  logic [1:0] nrz_clk_sel,
   input  logic       rate_tick,
   input  logic       ext_bclk,
   input  logic       bit_valid,
   input  logic       bit_data,
   output logic       bit_ready,
   input  logic       uart_line,
   output logic       line_out,
   output logic       bclk_out
);
   line_mode_e mode;
   logic ext_fall, phase, boundary, cur_vld, cur_bit;

   assign mode = resolve_mode(tx_manch, nrz_clk_sel);

   sltx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(ext_bclk), .fall_seen(ext_fall));

   sltx_timer u_timer (
      .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick),
      .use_ext(mode == LM_EXTCLK), .ext_fall(ext_fall),
      .phase(phase), .boundary(boundary));

   assign bit_ready = boundary & sync_sel;

   sltx_holder u_holder (
      .clk(clk), .rst_n(rst_n), .take(bit_ready), .in_valid(bit_valid),
      .in_bit(bit_data), .cur_vld(cur_vld), .cur_bit(cur_bit));

   sltx_encoder #(.HAS_CLK_OUT(HAS_CLK_OUT)) u_enc (
      .mode(mode), .phase(phase), .cur_vld(cur_vld), .cur_bit(cur_bit),
      .sync_sel(sync_sel), .uart_line(uart_line),
      .line_out(line_out), .bclk_out(bclk_out));

   assert_async_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !sync_sel |-> (line_out == uart_line && !bit_ready && !bclk_out));

   assert_ready_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      bit_ready |=> (!bit_ready || mode != $past(mode)));

   assert_manch_mid_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel && mode == LM_MANCH && cur_vld && !phase && rate_tick)
      |=> (line_out != $past(line_out) || mode != $past(mode) || !sync_sel));

   assert_idle_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_sel && !cur_vld) |-> line_out);

   assert_clk_rise_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == LM_INTCLK && $past(mode) == LM_INTCLK && sync_sel && $past(sync_sel)
       && $rose(bclk_out)) |-> $stable(line_out));

endmodule

// File: tb/sltx_top_tb_top.sv
module sltx_top_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sync_sel = 1'b1, tx_manch = 1'b0;
   logic [1:0] nrz_clk_sel = 2'd0;
   logic rate_tick = 1'b0, ext_bclk = 1'b0, bit_valid = 1'b0, bit_data = 1'b0;
   logic uart_line = 1'b1;
   logic bit_ready, line_out, bclk_out;

   int n_chk = 0, n_fail = 0;
   bit run = 1'b0;
   bit done = 1'b0;

   // bench model state
   logic m_phase, m_vld, m_bit, m_s1, m_s2, m_s3;

   always #2 clk = ~clk;

   sltx_top dut_i (
      .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .tx_manch(tx_manch),
      .nrz_clk_sel(nrz_clk_sel), .rate_tick(rate_tick), .ext_bclk(ext_bclk),
      .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
      .uart_line(uart_line), .line_out(line_out), .bclk_out(bclk_out));

   task automatic chk(input string tag, input string what, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
      end
   endtask

   function automatic int eff_mode(input logic manch, input logic [1:0] sel);
      // 0 plain, 1 internal clock, 2 external clock, 3 Manchester
      if (manch) return 3;
      if (sel == 2'd1) return 1;
      if (sel == 2'd2) return 2;
      return 0;
   endfunction

   function automatic logic exp_line(input int md);
      if (!sync_sel) return uart_line;
      if (!m_vld) return 1'b1;
      if (md == 3) return m_phase ? m_bit : ~m_bit;
      return m_bit;
   endfunction

   function automatic string line_tag(input int md);
      if (!sync_sel) return "R2";
      if (!m_vld) return "R8";
      if (md == 3) return (nrz_clk_sel != 2'd0) ? "R5" : "R4";
      if (md == 1) return "R6";
      if (md == 2) return "R7";
      return "R3";
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         m_phase <= 1'b0; m_vld <= 1'b0; m_bit <= 1'b1;
         m_s1 <= 1'b0; m_s2 <= 1'b0; m_s3 <= 1'b0;
      end else if (run) begin
         int md;
         logic bnd;
         md = eff_mode(tx_manch, nrz_clk_sel);
         bnd = sync_sel & ((md == 2) ? (m_s3 & ~m_s2) : (rate_tick & m_phase));
         chk(line_tag(md), "line_out", line_out, exp_line(md));
         chk((sync_sel && md == 1) ? "R6" : (sync_sel ? "R3" : "R2"), "bclk_out",
             bclk_out, sync_sel && md == 1 && m_phase);
         chk((md == 2) ? "R7" : "R9", "bit_ready", bit_ready, bnd);
         m_s1 <= ext_bclk; m_s2 <= m_s1; m_s3 <= m_s2;
         if (md != 2 && rate_tick) m_phase <= ~m_phase;
         if (bnd) begin
            m_vld <= bit_valid;
            if (bit_valid) m_bit <= bit_data;
         end
      end
   end

   // pattern: 0 random, 1 zeros, 2 ones, 3 alternating
   task automatic segment(input logic s, input logic mn, input logic [1:0] cs,
                          input int tdiv, input int vpct, input int pat,
                          input int ehalf, input int ncyc);
      int tcnt = 0, ecnt = 0;
      logic alt = 1'b0;
      run = 1'b0;
      @(posedge clk); #1;
      rst_n = 1'b0; rate_tick = 1'b0; ext_bclk = 1'b0; bit_valid = 1'b0;
      sync_sel = s; tx_manch = mn; nrz_clk_sel = cs;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state before any tick
      chk("R1", "line_out", line_out, s ? 1'b1 : uart_line);
      chk("R1", "bclk_out", bclk_out, 1'b0);
      chk("R1", "bit_ready", bit_ready, 1'b0);
      run = 1'b1;
      for (int c = 0; c < ncyc; c++) begin
         @(posedge clk); #1;
         rate_tick = (tcnt == tdiv - 1);
         tcnt = (tcnt == tdiv - 1) ? 0 : tcnt + 1;
         ecnt++;
         if (ecnt >= ehalf) begin ecnt = 0; ext_bclk = ~ext_bclk; end
         bit_valid = (($urandom % 100) < vpct);
         case (pat)
            1: bit_data = 1'b0;
            2: bit_data = 1'b1;
            3: begin if (bit_ready) alt = ~alt; bit_data = alt; end
            default: bit_data = $urandom % 2;
         endcase
         uart_line = $urandom % 2;
      end
      @(negedge clk);
      run = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5A17));
      segment(1, 0, 2'd0, 2, 80, 0, 5, 600);   // R3 plain NRZ
      segment(1, 0, 2'd3, 4, 30, 0, 5, 500);   // R3 code 3 plain, sparse
      segment(1, 1, 2'd0, 1, 100, 1, 5, 400);  // R4 zeros, tick every cycle
      segment(1, 1, 2'd0, 3, 100, 2, 5, 400);  // R4 ones
      segment(1, 1, 2'd1, 2, 70, 0, 5, 500);   // R5 Manchester overrides
      segment(1, 1, 2'd2, 2, 70, 3, 5, 400);   // R5 Manchester overrides ext
      segment(1, 0, 2'd1, 2, 80, 0, 5, 600);   // R6 internal clock
      segment(1, 0, 2'd1, 3, 0, 0, 5, 300);    // R8 idle, clock runs
      segment(1, 0, 2'd2, 1, 80, 0, 4, 600);   // R7 ticks ignored
      segment(1, 0, 2'd2, 3, 90, 3, 7, 600);   // R7 slower ext clock
      segment(0, 0, 2'd1, 2, 80, 0, 5, 400);   // R2 pass-through
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule